// File: doc/BRIEF.md
# Selective Wake Configuration Supervisor

This block stands between a host write bus and the selective wake logic of a bus transceiver. It holds the wake enable, a configuration-complete flag and two interrupt enables, and it watches every byte write on the bus. Any write that touches the wake matching setup withdraws the configuration-complete flag. The host must then confirm the setup again before wake is allowed.

An error flag combines two conditions: wake is requested while the setup is unconfirmed, or the frame error counter reports an overflow. While that flag is high, a request to turn wake on is refused. The effective wake enable goes high only when the enable is set, the setup is confirmed and no error is present. An interrupt request is raised from each status flag whose enable is set.

The block is meant to be placed beside the frame matcher and the error counter. Those two blocks, and the rest of the register map, stay outside it.

Top module: `swk_supervisor`

## Requirements
- R1: After reset the wake enable is 0, the configuration-complete flag is 0, the overflow interrupt enable is 1 and the error interrupt enable is 0.
- R2: A write to address 10h loads the wake enable from data bit 7. A 0 is always accepted, and the other data bits have no effect.
- R3: A write to address 47h loads the configuration-complete flag from data bit 7.
- R4: A write to any address from 30h to 44h inclusive, or to 46h, clears the configuration-complete flag. Writes to 45h, 10h and addresses outside the decoded set leave it unchanged.
- R5: err_o equals (wake enable AND NOT configuration-complete) OR frame_ovf_i, combinationally.
- R6: A write of 1 in bit 7 to 10h while err_o is high leaves the wake enable unchanged.
- R7: wake_en_o is high exactly when the wake enable is 1, configuration-complete is 1 and err_o is 0.
- R8: irq_o equals (frame_ovf_i AND overflow interrupt enable) OR (err_o AND error interrupt enable). The overflow interrupt enable is loaded from bit 3 of a write to 56h, and the error interrupt enable is loaded from bit 6 of a write to 58h.
- R9: Writes to addresses outside {10h, 30h–44h, 46h, 47h, 56h, 58h}, and cycles with wr_en low, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| frame_ovf_i | input | 1 | Overflow flag from the frame error counter |
| wake_en_o | output | 1 | Effective selective wake enable |
| err_o | output | 1 | Combined selective wake error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences walk the enable and confirmation handshake. A setup write at 30h drops wake, while a write at 45h does not, which separates the inclusive clear range from its neighbour. An enable request made during an overflow is checked to stay refused after the overflow goes away, which separates rejection from simple masking. Random writes aimed at the decoded addresses, their neighbours and arbitrary addresses, mixed with random overflow pulses, test ordering effects such as clearing the setup while wake is on. Flipping single interrupt enables tells the two interrupt sources apart.

// File: rtl/swk_sup_pkg.sv
package swk_sup_pkg;

    // Control state held by the supervisor
    typedef struct packed {
        logic wake_en;
        logic cfg_done;
        logic ovf_ie;
        logic err_ie;
    } swk_regs_t;

    // Decoded write selects for one bus cycle
    typedef struct packed {
        logic sel_en;
        logic sel_cfg;
        logic sel_clr;
        logic sel_ovf_ie;
        logic sel_err_ie;
    } swk_sel_t;

    // Data bits picked out of a write
    typedef struct packed {
        logic en_bit;
        logic cfg_bit;
        logic ovf_ie_bit;
        logic err_ie_bit;
    } swk_wbits_t;

endpackage

// File: rtl/swk_addr_decode.sv
module swk_addr_decode
    import swk_sup_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] EN_ADDR     = AW'(8'h10),
    parameter logic [AW-1:0] CFG_ADDR    = AW'(8'h47),
    parameter logic [AW-1:0] CLR_LO      = AW'(8'h30),
    parameter logic [AW-1:0] CLR_HI      = AW'(8'h44),
    parameter logic [AW-1:0] CLR_EXTRA   = AW'(8'h46),
    parameter logic [AW-1:0] OVF_IE_ADDR = AW'(8'h56),
    parameter logic [AW-1:0] ERR_IE_ADDR = AW'(8'h58)
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    output swk_sel_t      sel
);

    logic in_range;

    always_comb begin
        in_range       = (wr_addr >= CLR_LO) && (wr_addr <= CLR_HI);
        sel.sel_en     = wr_en && (wr_addr == EN_ADDR);
        sel.sel_cfg    = wr_en && (wr_addr == CFG_ADDR);
        sel.sel_clr    = wr_en && (in_range || (wr_addr == CLR_EXTRA));
        sel.sel_ovf_ie = wr_en && (wr_addr == OVF_IE_ADDR);
        sel.sel_err_ie = wr_en && (wr_addr == ERR_IE_ADDR);
    end

endmodule

// File: rtl/swk_ctrl_regs.sv
module swk_ctrl_regs
    import swk_sup_pkg::*;
#(
    parameter bit OVF_IE_RST = 1'b1,
    parameter bit ERR_IE_RST = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  swk_sel_t   sel,
    input  swk_wbits_t wbits,
    input  logic       err_i,
    output swk_regs_t  regs_q
);

    localparam swk_regs_t REGS_RST = '{
        wake_en:  1'b0,
        cfg_done: 1'b0,
        ovf_ie:   OVF_IE_RST,
        err_ie:   ERR_IE_RST
    };

    swk_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (sel.sel_en) begin
            if (!wbits.en_bit) begin
                regs_d.wake_en = 1'b0;
            end else if (!err_i) begin
                regs_d.wake_en = 1'b1;
            end
        end
        if (sel.sel_cfg) begin
            regs_d.cfg_done = wbits.cfg_bit;
        end else if (sel.sel_clr) begin
            regs_d.cfg_done = 1'b0;
        end
        if (sel.sel_ovf_ie) begin
            regs_d.ovf_ie = wbits.ovf_ie_bit;
        end
        if (sel.sel_err_ie) begin
            regs_d.err_ie = wbits.err_ie_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/swk_status.sv
module swk_status
    import swk_sup_pkg::*;
(
    input  swk_regs_t regs,
    input  logic      frame_ovf_i,
    output logic      err_o,
    output logic      wake_en_o,
    output logic      irq_o
);

    logic unconfirmed;

    always_comb begin
        unconfirmed = regs.wake_en && !regs.cfg_done;
        err_o       = unconfirmed || frame_ovf_i;
        wake_en_o   = regs.wake_en && regs.cfg_done && !err_o;
        irq_o       = (frame_ovf_i && regs.ovf_ie) || (err_o && regs.err_ie);
    end

endmodule

// File: rtl/swk_supervisor.sv
module swk_supervisor
    import swk_sup_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [AW-1:0] EN_ADDR     = AW'(8'h10),
    parameter logic [AW-1:0] CFG_ADDR    = AW'(8'h47),
    parameter logic [AW-1:0] CLR_LO      = AW'(8'h30),
    parameter logic [AW-1:0] CLR_HI      = AW'(8'h44),
    parameter logic [AW-1:0] CLR_EXTRA   = AW'(8'h46),
    parameter logic [AW-1:0] OVF_IE_ADDR = AW'(8'h56),
    parameter logic [AW-1:0] ERR_IE_ADDR = AW'(8'h58),
    parameter int EN_BIT     = 7,
    parameter int CFG_BIT    = 7,
    parameter int OVF_IE_BIT = 3,
    parameter int ERR_IE_BIT = 6,
    parameter bit OVF_IE_RST = 1'b1,
    parameter bit ERR_IE_RST = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          frame_ovf_i,
    output logic          wake_en_o,
    output logic          err_o,
    output logic          irq_o
);

    swk_sel_t   sel;
    swk_wbits_t wbits;
    swk_regs_t  regs_q;

    always_comb begin
        wbits.en_bit     = wr_data[EN_BIT];
        wbits.cfg_bit    = wr_data[CFG_BIT];
        wbits.ovf_ie_bit = wr_data[OVF_IE_BIT];
        wbits.err_ie_bit = wr_data[ERR_IE_BIT];
    end

    swk_addr_decode #(
        .AW(AW), .EN_ADDR(EN_ADDR), .CFG_ADDR(CFG_ADDR),
        .CLR_LO(CLR_LO), .CLR_HI(CLR_HI), .CLR_EXTRA(CLR_EXTRA),
        .OVF_IE_ADDR(OVF_IE_ADDR), .ERR_IE_ADDR(ERR_IE_ADDR)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .sel     (sel)
    );

    swk_ctrl_regs #(
        .OVF_IE_RST(OVF_IE_RST), .ERR_IE_RST(ERR_IE_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .wbits  (wbits),
        .err_i  (err_o),
        .regs_q (regs_q)
    );

    swk_status u_status (
        .regs        (regs_q),
        .frame_ovf_i (frame_ovf_i),
        .err_o       (err_o),
        .wake_en_o   (wake_en_o),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/swk_supervisor_chk.sv
module swk_supervisor_chk
    import swk_sup_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [AW-1:0] EN_ADDR     = AW'(8'h10),
    parameter logic [AW-1:0] CFG_ADDR    = AW'(8'h47),
    parameter logic [AW-1:0] CLR_LO      = AW'(8'h30),
    parameter logic [AW-1:0] CLR_HI      = AW'(8'h44),
    parameter logic [AW-1:0] CLR_EXTRA   = AW'(8'h46),
    parameter logic [AW-1:0] OVF_IE_ADDR = AW'(8'h56),
    parameter logic [AW-1:0] ERR_IE_ADDR = AW'(8'h58),
    parameter int EN_BIT     = 7,
    parameter int CFG_BIT    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          frame_ovf_i,
    input logic          wake_en_o,
    input logic          err_o,
    input logic          irq_o,
    input swk_regs_t     regs_q
);

    logic          clr_hit;
    logic          decoded;
    logic [DW-1:0] other_en_bits;

    assign clr_hit = wr_en && (((wr_addr >= CLR_LO) && (wr_addr <= CLR_HI)) || (wr_addr == CLR_EXTRA));
    assign decoded = clr_hit || (wr_addr == EN_ADDR) || (wr_addr == CFG_ADDR)
                   || (wr_addr == OVF_IE_ADDR) || (wr_addr == ERR_IE_ADDR);
    assign other_en_bits = wr_data & ~(DW'(1) << EN_BIT);

    // R2: a cleared bit 7 turns wake off whatever the other bits hold
    a_r2_clear_en: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == EN_ADDR && !wr_data[EN_BIT] && other_en_bits != '0) |=> !regs_q.wake_en);

    // R3: confirmation bit follows the written data
    a_r3_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CFG_ADDR) |=> (regs_q.cfg_done == $past(wr_data[CFG_BIT])));

    // R4: setup writes withdraw confirmation
    a_r4_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> !regs_q.cfg_done);

    // R5: overflow always raises the error flag
    a_r5_ovf_err: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ovf_i |-> err_o);

    // R6: enable request refused during error
    a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == EN_ADDR && wr_data[EN_BIT] && err_o && !regs_q.wake_en) |=> !regs_q.wake_en);

    // R7: effective wake needs the full handshake
    a_r7_wake_gate: assert property (@(posedge clk) disable iff (!rst_n)
        wake_en_o |-> (regs_q.wake_en && regs_q.cfg_done && !err_o && !frame_ovf_i));

    // R8: enabled overflow reaches the interrupt line
    a_r8_ovf_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ovf_i && regs_q.ovf_ie) |-> irq_o);

    // R9: idle cycles and undecoded writes keep the state
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !decoded) |=> $stable(regs_q));

endmodule

bind swk_supervisor swk_supervisor_chk #(
    .AW(AW), .DW(DW), .EN_ADDR(EN_ADDR), .CFG_ADDR(CFG_ADDR),
    .CLR_LO(CLR_LO), .CLR_HI(CLR_HI), .CLR_EXTRA(CLR_EXTRA),
    .OVF_IE_ADDR(OVF_IE_ADDR), .ERR_IE_ADDR(ERR_IE_ADDR),
    .EN_BIT(EN_BIT), .CFG_BIT(CFG_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .frame_ovf_i (frame_ovf_i),
    .wake_en_o   (wake_en_o),
    .err_o       (err_o),
    .irq_o       (irq_o),
    .regs_q      (regs_q)
);

// File: tb/swk_supervisor_bench.sv
`timescale 1ns/1ps
module swk_supervisor_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       frame_ovf_i = 1'b0;
    logic       wake_en_o, err_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench reference state
    bit m_en, m_cfg, m_oie, m_eie;

    always #5 clk = ~clk;

    swk_supervisor u_swk_supervisor (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_ovf_i(frame_ovf_i),
        .wake_en_o(wake_en_o), .err_o(err_o), .irq_o(irq_o)
    );

    function automatic bit exp_err(bit ovf);
        return (m_en && !m_cfg) || ovf;
    endfunction

    function automatic bit exp_wake(bit ovf);
        return m_en && m_cfg && !exp_err(ovf);
    endfunction

    function automatic bit exp_irq(bit ovf);
        return (ovf && m_oie) || (exp_err(ovf) && m_eie);
    endfunction

    function automatic void model_write(bit we, bit [7:0] a, bit [7:0] d, bit ovf);
        bit e;
        e = exp_err(ovf);
        if (!we) return;
        if (a == 8'h10) begin
            if (!d[7]) m_en = 1'b0;
            else if (!e) m_en = 1'b1;
        end
        if (a == 8'h47) m_cfg = d[7];
        else if ((a >= 8'h30 && a <= 8'h44) || a == 8'h46) m_cfg = 1'b0;
        if (a == 8'h56) m_oie = d[3];
        if (a == 8'h58) m_eie = d[6];
    endfunction

    task automatic check_outs(string tag);
        bit [2:0] act, exp;
        act = {wake_en_o, err_o, irq_o};
        exp = {exp_wake(frame_ovf_i), exp_err(frame_ovf_i), exp_irq(frame_ovf_i)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {wake,err,irq} actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive one bus cycle after a falling edge, check, then advance the model
    task automatic cyc(bit we, bit [7:0] a, bit [7:0] d, bit ovf, string tag);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; frame_ovf_i = ovf;
        #1;
        check_outs(tag);
        model_write(we, a, d, ovf);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        m_en = 1'b0; m_cfg = 1'b0; m_oie = 1'b1; m_eie = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check_outs("R1 in reset, no overflow");
        frame_ovf_i = 1'b1;
        #1;
        check_outs("R1 in reset, overflow irq on by default");
        frame_ovf_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3 confirm then R2 enable
        cyc(1, 8'h47, 8'h80, 0, "R3 idle before confirm");
        cyc(1, 8'h10, 8'h80, 0, "R3 confirm taken");
        cyc(0, 8'h00, 8'h00, 0, "R7 wake on after handshake");
        // R4 neighbour 45h keeps, 30h clears
        cyc(1, 8'h45, 8'hFF, 0, "R4 write 45h");
        cyc(1, 8'h30, 8'h00, 0, "R4 45h left wake on");
        cyc(0, 8'h00, 8'h00, 0, "R4 R5 30h withdrew confirm, error up");
        cyc(1, 8'h47, 8'h80, 0, "R5 err while unconfirmed");
        cyc(1, 8'h44, 8'h01, 0, "R7 reconfirmed");
        cyc(1, 8'h47, 8'h80, 0, "R4 44h edge cleared");
        cyc(1, 8'h46, 8'h00, 0, "R7 reconfirmed again");
        cyc(0, 8'h00, 8'h00, 0, "R4 46h cleared");
        // R2 clear with other bits set
        cyc(1, 8'h10, 8'h7F, 0, "R5 before disable");
        cyc(1, 8'h47, 8'h80, 0, "R2 disabled despite low bits");
        // R6 request refused during overflow, not re-applied later
        cyc(1, 8'h10, 8'h80, 1, "R6 request during overflow");
        cyc(0, 8'h00, 8'h00, 0, "R6 overflow gone, wake still off");
        cyc(1, 8'h10, 8'h80, 0, "R6 second request");
        cyc(0, 8'h00, 8'h00, 0, "R6 accepted when error low");
        // R8 interrupt enables
        cyc(1, 8'h58, 8'h40, 0, "R8 before error irq enable");
        cyc(1, 8'h31, 8'h00, 0, "R8 error irq enabled");
        cyc(1, 8'h56, 8'h00, 0, "R8 error irq from unconfirmed");
        cyc(1, 8'h58, 8'h00, 1, "R8 overflow irq disabled, error irq on");
        cyc(0, 8'h00, 8'h00, 1, "R8 both irq enables off");
        // R9 undecoded writes and idle cycles
        cyc(1, 8'h20, 8'hFF, 0, "R9 before undecoded writes");
        cyc(1, 8'h45, 8'hFF, 0, "R9 after 20h");
        cyc(1, 8'h57, 8'hFF, 0, "R9 after 45h");
        cyc(0, 8'h47, 8'h80, 0, "R9 after 57h");
        cyc(0, 8'h00, 8'h00, 0, "R9 strobe low ignored");

        for (int i = 0; i < 3000; i++) begin
            bit [7:0] a;
            case ($urandom % 9)
                0: a = 8'h10;
                1: a = 8'h47;
                2: a = 8'h56;
                3: a = 8'h58;
                4: a = 8'h30 + 8'($urandom % 21);
                5: a = 8'h46;
                6: a = 8'h45;
                7: a = 8'h2F;
                default: a = 8'($urandom);
            endcase
            cyc(($urandom % 10) < 7, a, 8'($urandom), ($urandom % 6) == 0,
                "R2/R3/R4/R5/R6/R7/R8/R9 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule